// File: doc/BRIEF.md
# Skewed Dual-Core Lockstep Comparator

This block sits between two copies of a processor core that run the same instruction stream. The main core takes its inputs straight from the system. The checker core runs a fixed number of cycles behind it, so that one disturbance, such as a voltage spike or a particle strike, does not hit both copies at the same point of the computation. The block delays the main core's input stream before it reaches the checker. It also delays the main core's output bundle (address, write data, control and a step-valid strobe) by the same number of cycles, so that the two bundles meet in the same cycle. Both cores leave reset in the same state. When the aligned bundles agree, nothing happens and execution goes on.

The core streams carry only a valid strobe and have no ready. The cores cannot be stalled, so the block never applies back-pressure: every cycle with a valid step is taken and compared. In a cycle where the delayed main valid and the checker valid are both high, the three fields are compared. A disagreement between the two valid strobes is itself a mismatch. On the first mismatch after reset or after a software clear, the block sets a sticky error flag and fires a one-cycle interrupt. It can also assert a reset request. At the same moment it records the step number and a mask of the differing fields.

Top module: `lockstep_skew_cmp`

## Requirements
- R1: `chk_in_vld`/`chk_in_data` equal `in_vld`/`in_data` as they were exactly SKEW clock cycles earlier.
- R2: When the checker stream equals the main stream shifted by SKEW cycles, with or without idle gaps, `err_flag` and `err_irq` stay low.
- R3: If both aligned valids are high and any field differs, `err_flag` goes high on the next clock edge. `cap_mask` marks each differing field: bit 0 address, bit 1 write data, bit 2 control.
- R4: If the aligned valids differ, the step is a mismatch and `cap_mask` is 4'b1000 (bit 3 = valid), whatever the field values are.
- R5: `err_flag` stays high until `err_clr` is sampled high. A clear with no new mismatch in that cycle drops it on the next edge.
- R6: `err_irq` is high for exactly one cycle, together with the flag rising, on the first mismatch after reset or clear. Further mismatches while the flag is set give no pulse.
- R7: On that first mismatch, `cap_step` takes the number of valid main steps compared before the failing one, counted from 0 since reset. `cap_mask` takes the field mask. Both hold through later mismatches and through a clear, until the next first mismatch.
- R8: During the first SKEW cycles after reset no comparison takes place. A checker valid in the cycle right after that window is compared.
- R9: `rst_req` follows `err_flag` when RST_EN is 1 (the default) and is 0 otherwise.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Valid of the input step given to the main core |
| in_data | input | IN_W | Input data given to the main core |
| chk_in_vld | output | 1 | Delayed input valid for the checker core |
| chk_in_data | output | IN_W | Delayed input data for the checker core |
| main_vld | input | 1 | Main core step valid |
| main_addr | input | ADDR_W | Main core address |
| main_wdata | input | DATA_W | Main core write data |
| main_ctrl | input | CTRL_W | Main core control signals |
| chk_vld | input | 1 | Checker core step valid |
| chk_addr | input | ADDR_W | Checker core address |
| chk_wdata | input | DATA_W | Checker core write data |
| chk_ctrl | input | CTRL_W | Checker core control signals |
| err_clr | input | 1 | Software clear of the error flag |
| err_flag | output | 1 | Sticky mismatch flag |
| err_irq | output | 1 | One-cycle interrupt on the first mismatch |
| rst_req | output | 1 | Reset request |
| cap_step | output | CNT_W | Step number of the first mismatch |
| cap_mask | output | 4 | Differing fields of the first mismatch |

## Verification
Most internal faults show at the ports within SKEW+1 cycles of the step they concern. A skew pipeline one stage short or long misaligns every compared pair, so a clean stream raises the flag on its first valid step. A step counter that counts wrongly shows up as a wrong `cap_step` at the first injected fault. A fill counter that ends too early or too late flags, or misses, a checker valid forced in the cycles around the end of the fill window. A flag or capture register that loses its sticky behaviour shows up when a second fault or a clear follows.

// File: rtl/lsk_pkg.sv
`timescale 1ns/1ps
package lsk_pkg;
  localparam int FLD_N    = 4;
  localparam int FLD_ADDR = 0;
  localparam int FLD_DATA = 1;
  localparam int FLD_CTRL = 2;
  localparam int FLD_VLD  = 3;
  typedef logic [FLD_N-1:0] fld_mask_t;
endpackage

// File: rtl/lsk_delay.sv
`timescale 1ns/1ps
// Fixed-depth shift register, cleared by reset.
module lsk_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [DEPTH-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];
endmodule

// File: rtl/lsk_compare.sv
`timescale 1ns/1ps
// Combinational field comparison of two aligned bundles.
module lsk_compare
  import lsk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4
) (
  input  logic              m_vld,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [DATA_W-1:0] m_wdata,
  input  logic [CTRL_W-1:0] m_ctrl,
  input  logic              c_vld,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [DATA_W-1:0] c_wdata,
  input  logic [CTRL_W-1:0] c_ctrl,
  output fld_mask_t         diff
);
  always_comb begin
    diff = '0;
    if (m_vld != c_vld) begin
      diff[FLD_VLD] = 1'b1;
    end else if (m_vld) begin
      diff[FLD_ADDR] = (m_addr  != c_addr);
      diff[FLD_DATA] = (m_wdata != c_wdata);
      diff[FLD_CTRL] = (m_ctrl  != c_ctrl);
    end
  end
endmodule

// File: rtl/lsk_capture.sv
`timescale 1ns/1ps
// Fill window, step counter, sticky flag, interrupt and first-fault capture.
module lsk_capture
  import lsk_pkg::*;
#(
  parameter int SKEW   = 2,
  parameter int CNT_W  = 16,
  parameter bit RST_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             m_vld_d,
  input  fld_mask_t        diff,
  output logic             flag,
  output logic             irq,
  output logic             rst_req,
  output logic [CNT_W-1:0] cap_step,
  output fld_mask_t        cap_mask
);
  localparam int FILL_W = $clog2(SKEW + 1);
  localparam logic [FILL_W-1:0] FILL_END = FILL_W'(SKEW);

  logic [FILL_W-1:0] fill_q;
  logic [CNT_W-1:0]  step_q;
  logic              armed, hit, first;

  assign armed = (fill_q == FILL_END);
  assign hit   = armed && (|diff);
  assign first = hit && (!flag || clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q   <= '0;
      step_q   <= '0;
      flag     <= 1'b0;
      irq      <= 1'b0;
      cap_step <= '0;
      cap_mask <= '0;
    end else begin
      if (!armed) fill_q <= fill_q + FILL_W'(1);
      if (armed && m_vld_d) step_q <= step_q + CNT_W'(1);
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      irq <= first;
      if (first) begin
        cap_step <= step_q;
        cap_mask <= diff;
      end
    end
  end

  if (RST_EN) begin : g_rreq
    assign rst_req = flag;
  end else begin : g_norreq
    assign rst_req = 1'b0;
  end
endmodule

// File: rtl/lockstep_skew_cmp.sv
`timescale 1ns/1ps
module lockstep_skew_cmp
  import lsk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4,
  parameter int IN_W   = 16,
  parameter int SKEW   = 2,
  parameter int CNT_W  = 16,
  parameter bit RST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IN_W-1:0]   in_data,
  output logic              chk_in_vld,
  output logic [IN_W-1:0]   chk_in_data,
  input  logic              main_vld,
  input  logic [ADDR_W-1:0] main_addr,
  input  logic [DATA_W-1:0] main_wdata,
  input  logic [CTRL_W-1:0] main_ctrl,
  input  logic              chk_vld,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [DATA_W-1:0] chk_wdata,
  input  logic [CTRL_W-1:0] chk_ctrl,
  input  logic              err_clr,
  output logic              err_flag,
  output logic              err_irq,
  output logic              rst_req,
  output logic [CNT_W-1:0]  cap_step,
  output logic [FLD_N-1:0]  cap_mask
);
  localparam int IN_BW  = 1 + IN_W;
  localparam int OUT_BW = 1 + ADDR_W + DATA_W + CTRL_W;

  logic              dm_vld;
  logic [ADDR_W-1:0] dm_addr;
  logic [DATA_W-1:0] dm_wdata;
  logic [CTRL_W-1:0] dm_ctrl;
  fld_mask_t         diff;

  lsk_delay #(.W(IN_BW), .DEPTH(SKEW)) u_in_dly (
    .clk(clk), .rst_n(rst_n),
    .d({in_vld, in_data}),
    .q({chk_in_vld, chk_in_data})
  );

  lsk_delay #(.W(OUT_BW), .DEPTH(SKEW)) u_out_dly (
    .clk(clk), .rst_n(rst_n),
    .d({main_vld, main_addr, main_wdata, main_ctrl}),
    .q({dm_vld, dm_addr, dm_wdata, dm_ctrl})
  );

  lsk_compare #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_cmp (
    .m_vld(dm_vld), .m_addr(dm_addr), .m_wdata(dm_wdata), .m_ctrl(dm_ctrl),
    .c_vld(chk_vld), .c_addr(chk_addr), .c_wdata(chk_wdata), .c_ctrl(chk_ctrl),
    .diff(diff)
  );

  lsk_capture #(.SKEW(SKEW), .CNT_W(CNT_W), .RST_EN(RST_EN)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(err_clr), .m_vld_d(dm_vld), .diff(diff),
    .flag(err_flag), .irq(err_irq), .rst_req(rst_req),
    .cap_step(cap_step), .cap_mask(cap_mask)
  );
endmodule

// File: rtl/lsk_sva.sv
`timescale 1ns/1ps
module lsk_sva #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 4,
  parameter int IN_W   = 16,
  parameter int SKEW   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [IN_W-1:0]   in_data,
  input logic              chk_in_vld,
  input logic [IN_W-1:0]   chk_in_data,
  input logic              main_vld,
  input logic [ADDR_W-1:0] main_addr,
  input logic [DATA_W-1:0] main_wdata,
  input logic [CTRL_W-1:0] main_ctrl,
  input logic              chk_vld,
  input logic [ADDR_W-1:0] chk_addr,
  input logic [DATA_W-1:0] chk_wdata,
  input logic [CTRL_W-1:0] chk_ctrl,
  input logic              err_clr,
  input logic              err_flag,
  input logic              err_irq,
  input logic [3:0]        cap_mask
);
  logic [2:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 3'd7) up_cnt <= up_cnt + 3'd1;
  end

  p_in_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt > 3'(SKEW)) |-> (chk_in_data == $past(in_data, SKEW)) &&
                            (chk_in_vld == $past(in_vld, SKEW)));

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err_flag) && up_cnt > 3'(SKEW)) |->
      ($past(chk_vld) != $past(main_vld, SKEW + 1)) ||
      ($past(chk_addr) != $past(main_addr, SKEW + 1)) ||
      ($past(chk_wdata) != $past(main_wdata, SKEW + 1)) ||
      ($past(chk_ctrl) != $past(main_ctrl, SKEW + 1)));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);

  p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> err_flag);

  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_irq && !err_clr) |=> !err_irq);

  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (cap_mask != 4'b0000));

  p_fill_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt <= 3'(SKEW)) |-> !err_flag);
endmodule

bind lockstep_skew_cmp lsk_sva #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .IN_W(IN_W), .SKEW(SKEW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
  .chk_in_vld(chk_in_vld), .chk_in_data(chk_in_data),
  .main_vld(main_vld), .main_addr(main_addr), .main_wdata(main_wdata), .main_ctrl(main_ctrl),
  .chk_vld(chk_vld), .chk_addr(chk_addr), .chk_wdata(chk_wdata), .chk_ctrl(chk_ctrl),
  .err_clr(err_clr), .err_flag(err_flag), .err_irq(err_irq), .cap_mask(cap_mask)
);

// File: tb/sim_lockstep_skew_cmp.sv
`timescale 1ns/1ps
module sim_lockstep_skew_cmp;
  localparam int AW = 32, DW = 32, CW = 4, IW = 16, SK = 2, CNTW = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [IW-1:0] in_data = '0;
  logic chk_in_vld;
  logic [IW-1:0] chk_in_data;
  logic err_clr = 1'b0;
  logic err_flag, err_irq, rst_req;
  logic [CNTW-1:0] cap_step;
  logic [3:0] cap_mask;

  // core models
  logic [AW-1:0] m_acc, c_acc, m_addr, c_addr;
  logic [DW-1:0] m_wdata, c_wdata;
  logic [CW-1:0] m_ctrl, c_ctrl;
  logic m_vld, c_vld;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc <= '0; m_vld <= 1'b0; m_addr <= '0; m_wdata <= '0; m_ctrl <= '0;
    end else begin
      m_vld <= in_vld;
      if (in_vld) begin
        m_acc <= m_acc + {16'h0, in_data};
        m_addr <= m_acc + {16'h0, in_data};
        m_wdata <= {in_data, ~in_data};
        m_ctrl <= in_data[3:0] ^ 4'h9;
      end
    end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_acc <= '0; c_vld <= 1'b0; c_addr <= '0; c_wdata <= '0; c_ctrl <= '0;
    end else begin
      c_vld <= chk_in_vld;
      if (chk_in_vld) begin
        c_acc <= c_acc + {16'h0, chk_in_data};
        c_addr <= c_acc + {16'h0, chk_in_data};
        c_wdata <= {chk_in_data, ~chk_in_data};
        c_ctrl <= chk_in_data[3:0] ^ 4'h9;
      end
    end
  end

  // fault injection on the checker outputs
  int unsigned c_cnt;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) c_cnt <= 0;
    else if (c_vld) c_cnt <= c_cnt + 1;
  end

  logic inj_on = 1'b0, force_vld = 1'b0, f_vld = 1'b0;
  int unsigned inj_k = 0;
  logic [AW-1:0] f_addr = '0;
  logic [DW-1:0] f_data = '0;
  logic [CW-1:0] f_ctrl = '0;
  logic hit_k;
  assign hit_k = inj_on && c_vld && (c_cnt == inj_k);

  logic chk_vld;
  logic [AW-1:0] chk_addr;
  logic [DW-1:0] chk_wdata;
  logic [CW-1:0] chk_ctrl;
  assign chk_vld   = (c_vld ^ (hit_k & f_vld)) | force_vld;
  assign chk_addr  = c_addr  ^ (hit_k ? f_addr : '0);
  assign chk_wdata = c_wdata ^ (hit_k ? f_data : '0);
  assign chk_ctrl  = c_ctrl  ^ (hit_k ? f_ctrl : '0);

  lockstep_skew_cmp #(.ADDR_W(AW), .DATA_W(DW), .CTRL_W(CW), .IN_W(IW),
                      .SKEW(SK), .CNT_W(CNTW), .RST_EN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .chk_in_vld(chk_in_vld), .chk_in_data(chk_in_data),
    .main_vld(m_vld), .main_addr(m_addr), .main_wdata(m_wdata), .main_ctrl(m_ctrl),
    .chk_vld(chk_vld), .chk_addr(chk_addr), .chk_wdata(chk_wdata), .chk_ctrl(chk_ctrl),
    .err_clr(err_clr), .err_flag(err_flag), .err_irq(err_irq), .rst_req(rst_req),
    .cap_step(cap_step), .cap_mask(cap_mask)
  );

  int total = 0, bad = 0, irq_cnt = 0;
  always @(negedge clk) if (rst_n && err_irq) irq_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0; err_clr = 1'b0;
    inj_on = 1'b0; f_vld = 1'b0; f_addr = '0; f_data = '0; f_ctrl = '0;
    repeat (3) @(negedge clk);
    irq_cnt = 0;
    rst_n = 1'b1;
  endtask

  task automatic run_steps(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b1; in_data = IW'($urandom);
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk);
        in_vld = 1'b0;
      end
    end
    @(negedge clk);
    in_vld = 1'b0;
    repeat (SK + 4) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R10 flag", err_flag, 0);
    check("R10 irq", err_irq, 0);
    check("R10 rst_req", rst_req, 0);
    check("R10 cap_step", cap_step, 0);
    check("R10 cap_mask", cap_mask, 0);
    check("R10 chk_in", {chk_in_vld, chk_in_data}, 0);
  endtask

  task automatic t_in_delay();
    logic [IW:0] hist [16];
    do_reset();
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);
      if (j >= SK) check("R1 delayed input", {chk_in_vld, chk_in_data}, 32'(hist[j-SK]));
      in_vld = j[0]; in_data = IW'($urandom);
      hist[j] = {in_vld, in_data};
    end
    in_vld = 1'b0;
  endtask

  task automatic t_clean();
    do_reset();
    run_steps(12, 1'b0);
    run_steps(12, 1'b1);
    check("R2 no flag on clean stream", err_flag, 0);
    check("R2 no irq on clean stream", irq_cnt, 0);
  endtask

  task automatic t_addr();
    do_reset();
    inj_k = 5; f_addr = 32'h0000_0100; inj_on = 1'b1;
    fork
      run_steps(10, 1'b1);
      begin
        do @(negedge clk); while (!hit_k);
        check("R3 flag low in faulted cycle", err_flag, 0);
        @(negedge clk);
        check("R3 flag high next cycle", err_flag, 1);
        check("R6 irq with flag", err_irq, 1);
      end
    join
    check("R3 addr mask", cap_mask, 4'b0001);
    check("R7 cap_step", cap_step, 5);
    check("R6 single pulse", irq_cnt, 1);
    check("R9 rst_req follows flag", rst_req, 1);
  endtask

  task automatic t_multi();
    do_reset();
    inj_k = 3; f_data = 32'h8000_0001; f_ctrl = 4'h4; inj_on = 1'b1;
    run_steps(8, 1'b0);
    check("R3 data+ctrl mask", cap_mask, 4'b0110);
    check("R7 cap_step multi", cap_step, 3);
  endtask

  task automatic t_second_and_clear();
    do_reset();
    inj_k = 2; f_addr = 32'h1; inj_on = 1'b1;
    run_steps(4, 1'b0);
    inj_k = c_cnt + 1; f_addr = '0; f_data = 32'h10;
    run_steps(4, 1'b0);
    check("R6 no pulse on second mismatch", irq_cnt, 1);
    check("R7 cap_step held", cap_step, 2);
    check("R7 cap_mask held", cap_mask, 4'b0001);
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    check("R5 clear drops flag", err_flag, 0);
    check("R9 rst_req drops", rst_req, 0);
    check("R7 cap_step kept over clear", cap_step, 2);
    inj_k = c_cnt + 3; f_data = '0; f_ctrl = 4'h1;
    run_steps(6, 1'b1);
    check("R5 flag set again", err_flag, 1);
    check("R6 pulse after clear", irq_cnt, 2);
    check("R7 new cap_step", cap_step, 32'(inj_k));
    check("R7 new cap_mask", cap_mask, 4'b0100);
    repeat (5) @(negedge clk);
    check("R5 flag sticky", err_flag, 1);
  endtask

  task automatic t_valid();
    do_reset();
    inj_k = 4; f_vld = 1'b1; f_addr = 32'hff; inj_on = 1'b1;
    run_steps(8, 1'b0);
    check("R4 valid mask", cap_mask, 4'b1000);
    check("R4 valid cap_step", cap_step, 4);
  endtask

  task automatic t_fill();
    force_vld = 1'b1;
    do_reset();
    repeat (SK) @(negedge clk);
    force_vld = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 suppressed in fill window", err_flag, 0);
    force_vld = 1'b1;
    do_reset();
    repeat (SK + 1) @(negedge clk);
    force_vld = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 compared after fill", err_flag, 1);
    check("R8 mask after fill", cap_mask, 4'b1000);
    check("R8 cap_step after fill", cap_step, 0);
  endtask

  initial begin
    t_reset();
    t_in_delay();
    t_clean();
    t_addr();
    t_multi();
    t_second_and_clear();
    t_valid();
    t_fill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule